// File: doc/BRIEF.md
# Audio High-Pass Filter

This block sits after an audio ADC decimator. It removes DC and low-frequency content from a stream of signed 24-bit PCM samples. Each sample arrives with a one-cycle valid strobe, and each filtered result leaves with a one-cycle valid strobe. The filter has two modes. In the first, a fixed first-order DC blocker with a corner near 3.7 Hz is used. In the second, a second-order section is used, with eight selectable corners that follow a sample-rate group input. A bypass passes samples through unchanged, and an inversion control flips the sign of every result.

All control inputs are captured on the edge that accepts a sample. They stay fixed for the whole computation of that sample. Arithmetic uses one multiplier, shared over five multiply-accumulate steps.

Top module: `aud_hpf`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid` is 0 and `out_data` is 0 until the first result. Between results, `out_data` holds its last value.
- R2: A sample is accepted on an edge where `in_valid` is 1 and no sample is in flight. Its result appears with `out_valid` high for exactly one cycle, 6 clock edges after the accepting edge. This latency is the same in every mode, including bypass.
- R3: An `in_valid` pulse that arrives while a sample is in flight is dropped. It produces no result and leaves the filter history untouched.
- R4: When `hpf_on` is 0, the result equals the input sample, after the inversion of R9. The filter history is not advanced.
- R5: When `hpf_on` is 1 and `app_mode` is 0, the filter computes acc = 65536·(x − x1) + p·y1, with p = 65536 − w0. Here w0 = floor((37·411775 + 5·fs)/(10·fs)), which places the corner at 3.7 Hz.
- R6: When `hpf_on` is 1 and `app_mode` is 1, the filter computes acc = 65536·x − 131072·x1 + 65536·x2 + 2p·y1 − a2·y2. Here p = 65536 − w and a2 = floor((p·p + 32768)/65536). x1 and x2 are the previous two accepted inputs, and y1 and y2 are the previous two filter outputs before inversion.
- R7: In application mode, w = floor((fc·411775 + fs/2)/fs). The value of fc is set by `cut_sel`, from code 0 to code 7. For the 8 kHz family (`rate_grp` 00, fs = 8000) the fc values are 82, 102, 131, 163, 204, 261, 327, 408. For the 11.025 kHz family (`rate_grp` 01, fs = 11025) they are 113, 141, 180, 225, 281, 360, 450, 563. For the 12 kHz family (`rate_grp` 10, fs = 12000) they are 122, 153, 196, 245, 306, 392, 490, 612. `rate_grp` 11 behaves exactly like 10.
- R8: The filtered output is y = (acc + 32768) >>> 16, computed as an arithmetic shift. It is then saturated to the range −8388608 to 8388607.
- R9: When `invert` is 1, the result is negated. The most negative value, −8388608, becomes 8388607 instead of overflowing.
- R10: The captured tuple {`hpf_on`, `app_mode`, `cut_sel`} is compared with the tuple of the previous accepted sample; after reset, that previous tuple is taken to be {1, 0, 000}. If they differ, all four history registers are cleared before the new sample is filtered. A change of `rate_grp` alone keeps the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 24 | Signed input sample |
| hpf_on | input | 1 | 1 filters, 0 bypasses |
| app_mode | input | 1 | 0 first-order DC blocker, 1 second-order section |
| cut_sel | input | 3 | Second-order corner code |
| rate_grp | input | 2 | Sample-rate family: 00 8 kHz, 01 11.025 kHz, 1x 12 kHz |
| invert | input | 1 | Negate the result (saturating) |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 24 | Signed result sample |

## Verification
Every result is due 6 edges after the edge that accepted its sample, whatever the mode. The bench stamps each expected value with the cycle count at the falling edge where it drives the strobe. The monitor then requires the result to appear at the falling edge exactly 7 counter ticks later. Samples are spaced 10 cycles apart, so each result is matched unambiguously against the front of the queue. Dropped strobes push nothing, and any output that arrives with an empty queue is reported.

// File: rtl/aud_hpf.sv
module aud_hpf #(
  parameter int W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_data,
  input  logic                hpf_on,
  input  logic                app_mode,
  input  logic [2:0]          cut_sel,
  input  logic [1:0]          rate_grp,
  input  logic                invert,
  output logic                out_valid,
  output logic signed [W-1:0] out_data
);
  localparam int CW   = 18;
  localparam int FRAC = 16;
  localparam int ACCW = W + CW + 6;
  localparam int NW   = 36;
  localparam logic signed [CW-1:0] ONE     = CW'(1 << FRAC);
  localparam logic signed [CW-1:0] NEG_ONE = CW'(-(1 << FRAC));
  localparam logic signed [CW-1:0] NEG_TWO = CW'(-2 * (1 << FRAC));
  localparam logic signed [W-1:0]  SMAX    = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0]  SMIN    = {1'b1, {(W-1){1'b0}}};

  function automatic int rate_hz(int g);
    return (g == 0) ? 8000 : (g == 1) ? 11025 : 12000;
  endfunction

  function automatic int fc_hz(int c, int g);
    case (c)
      0:       return (g == 0) ? 82  : (g == 1) ? 113 : 122;
      1:       return (g == 0) ? 102 : (g == 1) ? 141 : 153;
      2:       return (g == 0) ? 131 : (g == 1) ? 180 : 196;
      3:       return (g == 0) ? 163 : (g == 1) ? 225 : 245;
      4:       return (g == 0) ? 204 : (g == 1) ? 281 : 306;
      5:       return (g == 0) ? 261 : (g == 1) ? 360 : 392;
      6:       return (g == 0) ? 327 : (g == 1) ? 450 : 490;
      default: return (g == 0) ? 408 : (g == 1) ? 563 : 612;
    endcase
  endfunction

  function automatic int omega(int i);
    int g;
    int fs;
    g  = (i < 32) ? i / 8 : i - 32;
    fs = rate_hz(g);
    if (i < 32) return (fc_hz(i % 8, g) * 411775 + fs / 2) / fs;
    return (37 * 411775 + 5 * fs) / (10 * fs);
  endfunction

  logic [FRAC-1:0] wtab [NW];
  for (genvar i = 0; i < NW; i++) begin : g_wtab
    assign wtab[i] = FRAC'(omega(i));
  end

  logic [2:0]             cnt;
  logic                   accept;
  logic                   c_en, c_app, c_inv;
  logic [2:0]             c_cut;
  logic [1:0]             c_rate;
  logic [5:0]             widx;
  logic [FRAC:0]          p;
  logic [2*FRAC+1:0]      pp;
  logic signed [CW-1:0]   c1, c2n, kq;
  logic signed [W-1:0]    xs, x1, x2, y1, y2, vq, yf, res, yo;
  logic signed [ACCW-1:0] acc, prod, rnd;

  assign accept = in_valid && (cnt == 3'd0);
  assign widx   = c_app ? {1'b0, c_rate, c_cut} : {4'b1000, c_rate};
  assign p      = (FRAC+1)'(1 << FRAC) - {1'b0, wtab[widx]};
  assign pp     = {{(FRAC+1){1'b0}}, p} * {{(FRAC+1){1'b0}}, p};
  assign c1     = c_app ? CW'({p, 1'b0}) : CW'(p);
  assign c2n    = c_app ? -CW'((pp + (2*FRAC+2)'(1 << (FRAC - 1))) >> FRAC) : '0;

  always_comb begin
    kq = '0;
    vq = '0;
    case (cnt)
      3'd1: begin kq = ONE;                       vq = xs; end
      3'd2: begin kq = c_app ? NEG_TWO : NEG_ONE; vq = x1; end
      3'd3: begin kq = c_app ? ONE : '0;          vq = x2; end
      3'd4: begin kq = c1;                        vq = y1; end
      3'd5: begin kq = c2n;                       vq = y2; end
      default: ;
    endcase
  end

  assign prod = ACCW'(kq) * ACCW'(vq);
  assign rnd  = (acc + $signed(ACCW'(1 << (FRAC - 1)))) >>> FRAC;
  assign yf   = (&rnd[ACCW-1:W-1] || ~|rnd[ACCW-1:W-1]) ? rnd[W-1:0]
              : (rnd[ACCW-1] ? SMIN : SMAX);
  assign res  = c_en ? yf : xs;
  assign yo   = c_inv ? ((res == SMIN) ? SMAX : -res) : res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      acc       <= '0;
      xs        <= '0;
      x1        <= '0;
      x2        <= '0;
      y1        <= '0;
      y2        <= '0;
      c_en      <= 1'b1;
      c_app     <= 1'b0;
      c_cut     <= '0;
      c_rate    <= '0;
      c_inv     <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (accept) begin
        cnt    <= 3'd1;
        acc    <= '0;
        xs     <= in_data;
        c_en   <= hpf_on;
        c_app  <= app_mode;
        c_cut  <= cut_sel;
        c_rate <= rate_grp;
        c_inv  <= invert;
        if ({hpf_on, app_mode, cut_sel} != {c_en, c_app, c_cut}) begin
          x1 <= '0;
          x2 <= '0;
          y1 <= '0;
          y2 <= '0;
        end
      end else if (cnt == 3'd6) begin
        cnt       <= '0;
        out_valid <= 1'b1;
        out_data  <= yo;
        if (c_en) begin
          x2 <= x1;
          x1 <= xs;
          y2 <= y1;
          y1 <= yf;
        end
      end else if (cnt != 3'd0) begin
        acc <= acc + prod;
        cnt <= cnt + 3'd1;
      end
    end
  end
endmodule

// File: rtl/aud_hpf_chk.sv
module aud_hpf_chk #(
  parameter int W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                accept,
  input logic                hpf_on,
  input logic                invert,
  input logic signed [W-1:0] in_data,
  input logic                out_valid,
  input logic signed [W-1:0] out_data
);
  localparam logic signed [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R2

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(accept, 7)); // R2

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(!hpf_on && !invert, 7)) |-> (out_data == $past(in_data, 7))); // R4

  AST_INVERT_NO_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(invert, 7)) |-> (out_data != SMIN)); // R9

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data)); // R1
endmodule

bind aud_hpf aud_hpf_chk #(.W(W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .hpf_on    (hpf_on),
  .invert    (invert),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/aud_hpf_tb_top.sv
`timescale 1ns/1ps
module aud_hpf_tb_top;
  localparam int W = 24;
  localparam longint SMAX = 8388607;
  localparam longint SMIN = -8388608;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic hpf_on = 1'b1, app_mode = 1'b0, invert = 1'b0;
  logic [2:0] cut_sel = 3'd0;
  logic [1:0] rate_grp = 2'd0;
  logic signed [W-1:0] in_data = '0;
  logic out_valid;
  logic signed [W-1:0] out_data;
  int cyc = 0, errs = 0, checks = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  aud_hpf #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .hpf_on(hpf_on), .app_mode(app_mode), .cut_sel(cut_sel), .rate_grp(rate_grp),
    .invert(invert), .out_valid(out_valid), .out_data(out_data));

  typedef struct { longint val; int at; string tag; } item_t;
  item_t sb [$];
  longint mx1 = 0, mx2 = 0, my1 = 0, my2 = 0;
  logic [4:0] mcfg = 5'b10000;
  int fc_tab [3][8] = '{'{82, 102, 131, 163, 204, 261, 327, 408},
                        '{113, 141, 180, 225, 281, 360, 450, 563},
                        '{122, 153, 196, 245, 306, 392, 490, 612}};

  function automatic longint sat(longint v);
    return (v > SMAX) ? SMAX : (v < SMIN) ? SMIN : v;
  endfunction

  task automatic model(input longint x, output longint y);
    int g, fs;
    longint w, p, acc, r;
    g  = (rate_grp >= 2) ? 2 : int'(rate_grp);
    fs = (g == 0) ? 8000 : (g == 1) ? 11025 : 12000;
    if ({hpf_on, app_mode, cut_sel} != mcfg) begin
      mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
    end
    mcfg = {hpf_on, app_mode, cut_sel};
    if (!hpf_on) r = x;
    else begin
      w = app_mode ? (longint'(fc_tab[g][cut_sel]) * 411775 + fs / 2) / fs
                   : (37 * 411775 + 5 * longint'(fs)) / (10 * longint'(fs));
      p = 65536 - w;
      if (app_mode)
        acc = 65536 * x - 131072 * mx1 + 65536 * mx2 + 2 * p * my1 - ((p * p + 32768) >>> 16) * my2;
      else
        acc = 65536 * (x - mx1) + p * my1;
      r = sat((acc + 32768) >>> 16);
      mx2 = mx1; mx1 = x; my2 = my1; my1 = r;
    end
    y = invert ? ((r == SMIN) ? SMAX : -r) : r;
  endtask

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic send(input longint x, input string tag);
    item_t it;
    longint e;
    @(negedge clk);
    model(x, e);
    it.val = e; it.at = cyc; it.tag = tag;
    sb.push_back(it);
    in_data = W'(x);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic overlap(input longint x, input longint junk);
    item_t it;
    longint e;
    @(negedge clk);
    model(x, e);
    it.val = e; it.at = cyc; it.tag = "R3 sample with busy strobe";
    sb.push_back(it);
    in_data = W'(x);
    in_valid = 1'b1;
    @(negedge clk);
    in_data = W'(junk);
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) check(1'b0, "R3 unexpected output", out_data, 0);
      else begin
        item_t it;
        it = sb.pop_front();
        check(out_data == it.val, it.tag, out_data, it.val);
        check(cyc - it.at == 7, "R2 latency", cyc - it.at, 7);
      end
    end
  end

  initial begin
    #(4 * 100000);
    check(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_data == '0, "R1 reset state", out_data, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1 idle after reset", out_valid, 0);

    hpf_on = 1'b0;
    send(1000, "R4 bypass positive");
    send(-5, "R4 bypass negative");
    send(SMIN, "R4 bypass min");
    send(SMAX, "R4 bypass max");
    invert = 1'b1;
    send(SMIN, "R9 invert saturates min");
    send(123, "R9 invert bypass");
    invert = 1'b0;

    hpf_on = 1'b1;
    for (int i = 0; i < 12; i++) send(400000, "R5 audio step R10 enable clears");
    rate_grp = 2'd1;
    for (int i = 0; i < 4; i++) send(-300000, "R5 audio rate change keeps history R10");

    app_mode = 1'b1; cut_sel = 3'd0; rate_grp = 2'd0;
    for (int i = 0; i < 10; i++) send((i % 3 == 0) ? 500000 : -200000 * i, "R6 application code 0");
    cut_sel = 3'd7; rate_grp = 2'd2;
    for (int i = 0; i < 8; i++) send(300000, "R7 code 7 group 10");
    rate_grp = 2'd3;
    for (int i = 0; i < 4; i++) send(300000, "R7 group 11 as group 10");
    cut_sel = 3'd3; rate_grp = 2'd1;
    for (int i = 0; i < 4; i++) send(-700000 + 250000 * i, "R7 code 3 group 01");

    for (int i = 0; i < 8; i++) send((i % 2) ? SMIN : SMAX, "R8 saturation");

    invert = 1'b1;
    for (int i = 0; i < 4; i++) send(200000 - 90000 * i, "R9 inverted filtered");
    invert = 1'b0;

    app_mode = 1'b0;
    send(600000, "R10 mode change clears");
    send(600000, "R10 after mode change");
    app_mode = 1'b1; cut_sel = 3'd5;
    send(-600000, "R10 code change clears");
    send(-100000, "R10 after code change");

    overlap(250000, -8000000);
    send(250000, "R3 history untouched by dropped strobe");

    repeat (20) @(negedge clk);
    check(sb.size() == 0, "R3 all results delivered", sb.size(), 0);
    finish_run();
  end
endmodule